// File: doc/BRIEF.md
# Programmable Bidirectional Latch Pin Bank

This block looks after six general-purpose pins. Each pin can act as an input that senses a level from an outside source, or as an output that drives a stored value. Two byte-wide registers are loaded through a simple strobe-and-select write port. The direction register chooses input or output for each pin. The content register holds the level each output pin drives. The block gives a per-pin output enable and a per-pin output value, so tri-state pad drivers can sit outside it.

A read of the content register returns one byte. In that byte, a pin set as an output shows its programmed value, and a pin set as an input shows the level sensed on it after a two-flop synchronizer. The direction register can also be read back. In both registers, latch 0 sits in the most significant bit and latch 5 sits in bit 2. The two lowest bits carry no function.

After reset every pin is an input and no pin drives. The intended start-up order is to load the content register first and the direction register second, so that a pin starts driving its intended level at once.

Top module: `pl_latch_bank`

## Requirements
- R1: While `rst` is high at a clock edge, all registers clear. After that edge `pin_oe`, `pin_out` and `rd_data` are all zero, so every pin is a non-driving input.
- R2: A write with `wr_sel`=1 loads the direction register. Byte bit 7-i sets the direction of latch i, for i = 0..5. A bit value of 1 makes the pin an output and 0 makes it an input. The value appears on `pin_oe[i]` in the cycle after the strobe, and `pin_oe` changes only on such a write.
- R3: A write with `wr_sel`=0 loads the content register. Byte bit 7-i is the data for latch i. `pin_out[i]` shows the stored bit in the cycle after the strobe.
- R4: A content write while a pin is an input is still stored. When the pin is later made an output, it drives that value with no new content write.
- R5: A read with `rd_sel`=0 puts a byte on `rd_data` in the cycle after `rd_stb`. Bit 7-i holds the stored data of latch i if the latch is an output, or its synchronized sensed level if it is an input. Bits 1 and 0 are 0.
- R6: Levels on `pin_in` pass through two flops. A read strobed at the first or second clock edge after a level change still returns the old level. A read strobed at the third edge returns the new level.
- R7: A read with `rd_sel`=1 returns the direction register, with latch i in bit 7-i and bits 1 and 0 equal to 0.
- R8: Bits 1 and 0 of a written byte have no effect on either register.
- R9: When a read and a write fall in the same cycle, the read returns the register values held before that write.
- R10: `rd_data` holds its value in every cycle without `rd_stb`, even when the pins or the registers change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| wr_sel | input | 1 | Write target: 0 content, 1 direction |
| wr_byte | input | 8 | Byte to write |
| rd_stb | input | 1 | Read strobe |
| rd_sel | input | 1 | Read source: 0 merged content, 1 direction |
| rd_data | output | 8 | Registered read result |
| pin_in | input | 6 | Levels sensed on the pins |
| pin_oe | output | 6 | Per-pin output enable (1 = drive) |
| pin_out | output | 6 | Per-pin value to drive |

## Verification
The hardest window to reach is the pair of read results taken while a new pin level is still moving through the synchronizer. The stimulus changes `pin_in` and holds `rd_stb` high at the same falling edge. It then checks the three reads that follow, one clock apart: two must show the old level and the third the new one. The same-cycle read and write is reached in a similar way, by raising both strobes at one falling edge. Random sequences of writes, pin changes and reads then cover the mix of directions around these directed cases.

// File: rtl/pl_pkg.sv
package pl_pkg;

    localparam int LAT_N  = 6;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - LAT_N;

    typedef logic [LAT_N-1:0]  lat_vec_t;
    typedef logic [BYTE_W-1:0] ctl_byte_t;

    typedef enum logic {
        SEL_CONTENT   = 1'b0,
        SEL_DIRECTION = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic      stb;
        reg_sel_e  sel;
        ctl_byte_t data;
    } wr_req_t;

    typedef struct packed {
        lat_vec_t dir;
        lat_vec_t dat;
    } lat_cfg_t;

    // latch i lives at byte bit BYTE_W-1-i
    function automatic lat_vec_t byte_to_lat(input ctl_byte_t b);
        lat_vec_t v;
        for (int i = 0; i < LAT_N; i++) begin
            v[i] = b[BYTE_W-1-i];
        end
        return v;
    endfunction

    function automatic ctl_byte_t lat_to_byte(input lat_vec_t v);
        ctl_byte_t b;
        b = '0;
        for (int i = 0; i < LAT_N; i++) begin
            b[BYTE_W-1-i] = v[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pl_cfg_regs.sv
module pl_cfg_regs
    import pl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_req_t  req,
    output lat_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (req.stb) begin
            if (req.sel == SEL_DIRECTION) begin
                cfg.dir <= byte_to_lat(req.data);
            end else begin
                cfg.dat <= byte_to_lat(req.data);
            end
        end
    end

endmodule

// File: rtl/pl_in_sync.sv
module pl_in_sync
    import pl_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  lat_vec_t raw,
    output lat_vec_t sensed
);

    for (genvar g = 0; g < LAT_N; g++) begin : g_pin
        logic [DEPTH-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain[0] <= raw[g];
                for (int k = 1; k < DEPTH; k++) begin
                    chain[k] <= chain[k-1];
                end
            end
        end
        assign sensed[g] = chain[DEPTH-1];
    end

endmodule

// File: rtl/pl_readback.sv
module pl_readback
    import pl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_stb,
    input  reg_sel_e  rd_sel,
    input  lat_cfg_t  cfg,
    input  lat_vec_t  sensed,
    output ctl_byte_t rd_data
);

    lat_vec_t  merged;
    ctl_byte_t nxt;

    always_comb begin
        merged = (cfg.dir & cfg.dat) | (~cfg.dir & sensed);
        if (rd_sel == SEL_DIRECTION) begin
            nxt = lat_to_byte(cfg.dir);
        end else begin
            nxt = lat_to_byte(merged);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= nxt;
        end
    end

endmodule

// File: rtl/pl_latch_bank.sv
module pl_latch_bank
    import pl_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_stb,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [LAT_N-1:0]  pin_in,
    output logic [LAT_N-1:0]  pin_oe,
    output logic [LAT_N-1:0]  pin_out
);

    wr_req_t  req;
    lat_cfg_t cfg;
    lat_vec_t sensed;

    always_comb begin
        req.stb  = wr_stb;
        req.sel  = reg_sel_e'(wr_sel);
        req.data = wr_byte;
    end

    pl_cfg_regs u_regs (
        .clk (clk),
        .rst (rst),
        .req (req),
        .cfg (cfg)
    );

    pl_in_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .sensed (sensed)
    );

    pl_readback u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .rd_sel  (reg_sel_e'(rd_sel)),
        .cfg     (cfg),
        .sensed  (sensed),
        .rd_data (rd_data)
    );

    assign pin_oe  = cfg.dir;
    assign pin_out = cfg.dat;

endmodule

// File: rtl/pl_latch_bank_chk.sv
module pl_latch_bank_chk
    import pl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic              wr_sel,
    input logic [BYTE_W-1:0] wr_byte,
    input logic              rd_stb,
    input logic              rd_sel,
    input logic [BYTE_W-1:0] rd_data,
    input logic [LAT_N-1:0]  pin_oe,
    input logic [LAT_N-1:0]  pin_out
);

    AST_RESET_HIZ: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && rd_data == '0)); // R1

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_sel) |=> pin_oe == byte_to_lat($past(wr_byte))); // R2

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && wr_sel) |=> $stable(pin_oe)); // R2

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_sel) |=> pin_out == byte_to_lat($past(wr_byte))); // R3

    AST_RD_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !rd_sel) |=>
            ((byte_to_lat(rd_data) ^ $past(pin_out)) & $past(pin_oe)) == '0); // R5

    AST_RD_DIR: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_sel) |=>
            (byte_to_lat(rd_data) == $past(pin_oe) && rd_data[PAD_W-1:0] == '0)); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data)); // R10

endmodule

bind pl_latch_bank pl_latch_bank_chk u_chk (.*);

// File: tb/sim_pl_latch_bank.sv
`timescale 1ns/1ps
module sim_pl_latch_bank;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_stb, wr_sel, rd_stb, rd_sel;
    logic [7:0] wr_byte;
    logic [7:0] rd_data;
    logic [5:0] pin_in, pin_oe, pin_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [5:0] m_dir = '0, m_dat = '0, m_pin = '0;

    always #2.5 clk = ~clk;

    pl_latch_bank u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_byte(wr_byte),
        .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic logic [5:0] lat_of(input logic [7:0] b);
        logic [5:0] v;
        for (int i = 0; i < 6; i++) v[i] = b[7-i];
        return v;
    endfunction

    function automatic logic [7:0] byte_of(input logic [5:0] v);
        logic [7:0] b = 8'h00;
        for (int i = 0; i < 6; i++) b[7-i] = v[i];
        return b;
    endfunction

    function automatic logic [7:0] exp_read(input logic sel);
        if (sel) return byte_of(m_dir);
        return byte_of((m_dir & m_dat) | (~m_dir & m_pin));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag);
        check({tag, " pin_oe"},  {2'b00, pin_oe},  {2'b00, m_dir});
        check({tag, " pin_out"}, {2'b00, pin_out}, {2'b00, m_dat});
    endtask

    task automatic do_write(input logic sel, input logic [7:0] b, input string tag);
        @(negedge clk);
        wr_stb = 1'b1; wr_sel = sel; wr_byte = b;
        @(negedge clk);
        wr_stb = 1'b0;
        if (sel) m_dir = lat_of(b); else m_dat = lat_of(b);
        chk_pins(tag);
    endtask

    task automatic do_read(input logic sel, input string tag);
        logic [7:0] e;
        @(negedge clk);
        e = exp_read(sel);
        rd_stb = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_stb = 1'b0;
        check(tag, rd_data, e);
    endtask

    task automatic set_pins(input logic [5:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
        m_pin = v;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h1A2B3C4D));
        rst = 1'b1; wr_stb = 0; wr_sel = 0; wr_byte = 0;
        rd_stb = 0; rd_sel = 0; pin_in = 6'h2A;
        repeat (3) @(negedge clk);
        check("R1 pin_oe",  {2'b00, pin_oe},  8'h00);
        check("R1 pin_out", {2'b00, pin_out}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        rst = 1'b0;
        pin_in = 6'h00;
        repeat (3) @(negedge clk);

        // R3/R4: content stored while all pins are inputs
        do_write(1'b0, 8'b1011_0100, "R3 content while input");
        do_write(1'b1, 8'hFC, "R4 turn outputs on");
        check("R4 preloaded value driven", {2'b00, pin_out}, {2'b00, 6'b101101});
        do_read(1'b0, "R5 all outputs");

        // R8: low bits ignored; R7 direction readback
        do_write(1'b1, 8'b0101_0011, "R8 direction with low bits set");
        check("R2 latch1 latch3 out", {2'b00, pin_oe}, 8'b0000_1010);
        do_read(1'b1, "R7 R8 direction readback");
        do_write(1'b0, 8'b1111_1111, "R8 content with low bits set");
        do_read(1'b0, "R5 R8 mixed merge ones");

        // R5 merge with sensed inputs
        set_pins(6'b110011);
        do_read(1'b0, "R5 merge sensed");
        do_write(1'b0, 8'h00, "R3 clear content");
        do_read(1'b0, "R5 merge sensed zeros out");

        // R6 synchronizer lag
        do_write(1'b1, 8'h00, "R2 all inputs");
        set_pins(6'h00);
        @(negedge clk);
        pin_in = 6'h3F; rd_stb = 1'b1; rd_sel = 1'b0;
        @(negedge clk);
        check("R6 first edge old", rd_data, 8'h00);
        @(negedge clk);
        check("R6 second edge old", rd_data, 8'h00);
        @(negedge clk);
        rd_stb = 1'b0;
        check("R6 third edge new", rd_data, 8'hFC);
        m_pin = 6'h3F;

        // R9 same-cycle read and write
        do_write(1'b1, 8'hFC, "R2 all outputs");
        do_write(1'b0, 8'h00, "R3 zero content");
        @(negedge clk);
        wr_stb = 1'b1; wr_sel = 1'b0; wr_byte = 8'hFC;
        rd_stb = 1'b1; rd_sel = 1'b0;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        check("R9 read sees pre-write", rd_data, 8'h00);
        m_dat = 6'h3F;
        do_read(1'b0, "R9 later read sees write");

        // R10 hold without strobe
        held = rd_data;
        do_write(1'b0, 8'h54, "R3 content change");
        do_write(1'b1, 8'h30, "R2 direction change");
        set_pins(6'b010101);
        check("R10 rd_data held", rd_data, held);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 5;
            case (op)
                0: do_write(1'b1, 8'($urandom), "R2 random direction");
                1: do_write(1'b0, 8'($urandom), "R3 random content");
                2: set_pins(6'($urandom));
                3: do_read(1'b0, "R5 random merged read");
                default: do_read(1'b1, "R7 random direction read");
            endcase
        end

        done = 1;
        summary();
        $finish;
    end

endmodule